// File: doc/BRIEF.md
# Endpoint DMA Request Handshake Controller

This block drives the request line toward an external DMA controller for one double-buffered bulk endpoint. It decides when to ask for service, counts the bytes moved through the single-address acknowledge handshake, and tells the endpoint FIFO when a byte was read or written. When a buffer is finished it signals the handover to the FIFO. A finished buffer is a received packet that has been drained, a transmit buffer that has been filled, or a partial transmit buffer flushed by termination. The two buffers are used in turn.

Firmware sets the enable, the direction, the single or burst mode and the burst length. The FIFO reports whether the currently selected buffer can be serviced, and for reads it also reports the length of the received packet. A transfer ends in one of two ways. The external controller can signal end of transfer together with an acknowledge and a strobe, which raises a completion interrupt. Firmware can also clear the enable.

Top module: `epdma_req_ctrl`

## Requirements
- R1: While rst_n is low and after its release with dma_en low, dreq, fifo_rd_stb, fifo_wr_stb, buf_done and dma_irq are 0 and buf_sel is 0.
- R2: dreq is 1 in the cycle after an edge only if, at that edge, dma_en was 1, buf_ready was 1, no termination stop was pending and no byte hold was active.
- R3: A byte is taken on the first edge at which dma_ack_n is 0 together with the direction's strobe (rd_n when dir_wr is 0, wr_n when dir_wr is 1). In the next cycle it produces a one-cycle pulse on fifo_rd_stb (dir_wr 0) or fifo_wr_stb (dir_wr 1).
- R4: With burst_mode 0, dreq goes to 0 in the cycle after every byte. It returns once dma_ack_n has been seen high.
- R5: With burst_mode 1, dreq stays 1 for burst_len bytes and then drops until dma_ack_n is seen high. The count is reloaded for every new request, and a burst_len of 0 acts as 1.
- R6: With dir_wr 0, the byte that brings the selected buffer's count to pkt_len (or to 64) pulses buf_done and toggles buf_sel. It also drops dreq, whatever burst count remains.
- R7: With dir_wr 1, the 64th byte into a buffer pulses buf_done and toggles buf_sel. dreq then follows buf_ready for the newly selected buffer, once the acknowledge has been released.
- R8: Termination is recognized at the first edge where eot_n, dma_ack_n and at least one of rd_n or wr_n are all 0. It gives a one-cycle dma_irq pulse and forces dreq to 0, which stays 0 until dma_en has been seen at 0.
- R9: A termination with dir_wr 1 and at least one byte in the selected buffer pulses buf_done and toggles buf_sel. A termination with dir_wr 0 leaves the buffer selected.
- R10: When dma_en is 0, dreq is 0 in the next cycle, and an acknowledged strobe produces no FIFO strobe.
- R11: Each of the two buffers keeps its own byte count, and a buffer's count restarts at 0 after its handover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| eot_n | input | 1 | End of transfer, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dma_en | input | 1 | DMA enable from firmware |
| dir_wr | input | 1 | 1: memory writes the endpoint (transmit); 0: memory reads it (receive) |
| burst_mode | input | 1 | 1: burst requests; 0: single-cycle requests |
| burst_len | input | 4 | Bytes per burst request |
| buf_ready | input | 1 | Selected buffer can be serviced (packet present for reads, free for writes) |
| pkt_len | input | 7 | Length of the received packet in the selected buffer |
| dreq | output | 1 | DMA request |
| fifo_rd_stb | output | 1 | One byte read from the FIFO |
| fifo_wr_stb | output | 1 | One byte written to the FIFO |
| buf_sel | output | 1 | Buffer currently serviced |
| buf_done | output | 1 | Buffer handover: released after read, committed after write |
| dma_irq | output | 1 | DMA completion pulse |

## Verification
Every output is a register, so the result of inputs sampled at one rising edge appears just after that edge, and nothing is due later. This covers a new request, a dropped request after a byte, a handover, a buffer toggle and the interrupt. The bench changes inputs one nanosecond after an edge and reads outputs one nanosecond after the following edge. Each expected value therefore belongs to exactly the cycle in which its stimulus was sampled. Effects that span several cycles are checked at each cycle in turn: a request returning after the acknowledge is released, or the stop holding until the enable drops.

// File: rtl/epdma_pkg.sv
package epdma_pkg;
    localparam int unsigned BUF_BYTES = 64;
    localparam int unsigned BURST_W   = 4;
    localparam int unsigned NBUF      = 2;
    localparam int unsigned CNT_W     = $clog2(BUF_BYTES + 1);
    localparam int unsigned SEL_W     = $clog2(NBUF);

    typedef struct packed {
        logic               dreq;
        logic               rd_stb;
        logic               wr_stb;
        logic               done;
        logic               irq;
        logic               stop;
        logic               hold;
        logic [SEL_W-1:0]   sel;
        logic [BURST_W-1:0] bl;
    } ctl_t;
endpackage

// File: rtl/epdma_xfer_detect.sv
module epdma_xfer_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    input  logic eot_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic dir_wr,
    output logic xfer,
    output logic term
);
    logic act, act_q, tact, tact_q;

    // acknowledged strobe of the active direction
    assign act  = ~ack_n & (dir_wr ? ~wr_n : ~rd_n);
    // end of transfer is only valid with acknowledge and a strobe
    assign tact = ~ack_n & ~eot_n & (~rd_n | ~wr_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            tact_q <= 1'b0;
        end else begin
            act_q  <= act;
            tact_q <= tact;
        end
    end

    assign xfer = act & ~act_q;
    assign term = tact & ~tact_q;
endmodule

// File: rtl/epdma_buf_ctr.sv
module epdma_buf_ctr #(
    parameter int unsigned CNT_W = 7,
    parameter int unsigned NBUF  = 2,
    parameter int unsigned SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_sel
);
    logic [CNT_W-1:0] cnt [NBUF];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic [CNT_W-1:0] cnt_r;
        logic             hit;
        assign hit = (sel == SEL_W'(b));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt_r <= '0;
            else if (clr && hit)  cnt_r <= '0;
            else if (inc && hit)  cnt_r <= cnt_r + CNT_W'(1);
        end
        assign cnt[b] = cnt_r;
    end

    assign cnt_sel = cnt[sel];
endmodule

// File: rtl/epdma_req_ctrl.sv
module epdma_req_ctrl
    import epdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_ack_n,
    input  logic               eot_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               dma_en,
    input  logic               dir_wr,
    input  logic               burst_mode,
    input  logic [BURST_W-1:0] burst_len,
    input  logic               buf_ready,
    input  logic [CNT_W-1:0]   pkt_len,
    output logic               dreq,
    output logic               fifo_rd_stb,
    output logic               fifo_wr_stb,
    output logic [SEL_W-1:0]   buf_sel,
    output logic               buf_done,
    output logic               dma_irq
);
    ctl_t s_d, s_q;

    logic               xfer, term;
    logic               run, byte_ok, term_ok, pkt_end, handover;
    logic [CNT_W-1:0]   cnt_sel, cnt_nx;
    logic [BURST_W-1:0] reload;

    epdma_xfer_detect u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_n  (dma_ack_n),
        .eot_n  (eot_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .dir_wr (dir_wr),
        .xfer   (xfer),
        .term   (term)
    );

    epdma_buf_ctr #(
        .CNT_W (CNT_W),
        .NBUF  (NBUF),
        .SEL_W (SEL_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (s_q.sel),
        .inc     (byte_ok & ~handover),
        .clr     (handover),
        .cnt_sel (cnt_sel)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rd_stb = 1'b0;
        s_d.wr_stb = 1'b0;
        s_d.done   = 1'b0;
        s_d.irq    = 1'b0;

        run     = dma_en & ~s_q.stop;
        byte_ok = xfer & run;
        term_ok = term & run;
        cnt_nx  = cnt_sel + CNT_W'(1);

        if (dir_wr)
            pkt_end = byte_ok && (cnt_nx == CNT_W'(BUF_BYTES));
        else
            pkt_end = byte_ok && ((cnt_nx >= pkt_len) || (cnt_nx == CNT_W'(BUF_BYTES)));

        // write termination flushes a buffer that holds data
        handover = pkt_end | (term_ok & dir_wr & (byte_ok | (cnt_sel != '0)));

        if (!burst_mode || burst_len == '0) reload = BURST_W'(1);
        else                                 reload = burst_len;

        if (s_q.dreq && byte_ok) s_d.bl = s_q.bl - BURST_W'(1);
        else if (!s_q.dreq)      s_d.bl = reload;

        if (!dma_en || dma_ack_n)
            s_d.hold = 1'b0;
        else if (byte_ok && ((s_q.bl <= BURST_W'(1)) || handover))
            s_d.hold = 1'b1;

        if (!dma_en)      s_d.stop = 1'b0;
        else if (term_ok) s_d.stop = 1'b1;

        s_d.irq    = term_ok;
        s_d.rd_stb = byte_ok & ~dir_wr;
        s_d.wr_stb = byte_ok & dir_wr;
        s_d.done   = handover;
        if (handover) s_d.sel = s_q.sel + SEL_W'(1);

        s_d.dreq = dma_en & ~s_d.stop & ~s_d.hold & buf_ready & ~handover;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dreq        = s_q.dreq;
    assign fifo_rd_stb = s_q.rd_stb;
    assign fifo_wr_stb = s_q.wr_stb;
    assign buf_sel     = s_q.sel;
    assign buf_done    = s_q.done;
    assign dma_irq     = s_q.irq;
endmodule

// File: rtl/epdma_req_chk.sv
module epdma_req_chk
    import epdma_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             dma_en,
    input logic             buf_ready,
    input logic             burst_mode,
    input logic             dreq,
    input logic             fifo_rd_stb,
    input logic             fifo_wr_stb,
    input logic [SEL_W-1:0] buf_sel,
    input logic             buf_done,
    input logic             dma_irq
);
    // R10
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !dreq);

    // R2
    no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_ready |=> !dreq);

    // R4
    single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_rd_stb || fifo_wr_stb) && !$past(burst_mode)) |-> !dreq);

    // R6
    handover_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> (buf_sel != $past(buf_sel)));

    // R8
    irq_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> !dreq);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |=> !dma_irq);
endmodule

bind epdma_req_ctrl epdma_req_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_en      (dma_en),
    .buf_ready   (buf_ready),
    .burst_mode  (burst_mode),
    .dreq        (dreq),
    .fifo_rd_stb (fifo_rd_stb),
    .fifo_wr_stb (fifo_wr_stb),
    .buf_sel     (buf_sel),
    .buf_done    (buf_done),
    .dma_irq     (dma_irq)
);

// File: tb/epdma_req_ctrl_tb_top.sv
module epdma_req_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_ack_n = 1'b1, eot_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic       dma_en = 1'b0, dir_wr = 1'b0, burst_mode = 1'b0;
    logic [3:0] burst_len = 4'd0;
    logic       buf_ready = 1'b0;
    logic [6:0] pkt_len = 7'd3;
    logic       dreq, fifo_rd_stb, fifo_wr_stb, buf_done, dma_irq;
    logic [0:0] buf_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    epdma_req_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .dma_ack_n(dma_ack_n), .eot_n(eot_n),
        .rd_n(rd_n), .wr_n(wr_n), .dma_en(dma_en), .dir_wr(dir_wr),
        .burst_mode(burst_mode), .burst_len(burst_len), .buf_ready(buf_ready),
        .pkt_len(pkt_len), .dreq(dreq), .fifo_rd_stb(fifo_rd_stb),
        .fifo_wr_stb(fifo_wr_stb), .buf_sel(buf_sel), .buf_done(buf_done),
        .dma_irq(dma_irq)
    );

    typedef struct packed {
        logic       en, dir, bm;
        logic [3:0] blen;
        logic       rdy, ackn, rdn, wrn, eotn;
        logic [6:0] plen;
        logic [5:0] exp; // dreq, rd_stb, wr_stb, done, sel, irq
    } vec_t;

    localparam vec_t VEC [18] = '{
        '{1,0,0,4'd0,1,1,1,1,1,7'd3,6'b100000},
        '{1,0,0,4'd0,1,0,0,1,1,7'd3,6'b010000},
        '{1,0,0,4'd0,1,1,1,1,1,7'd3,6'b100000},
        '{1,0,0,4'd0,1,0,0,1,1,7'd3,6'b010000},
        '{1,0,0,4'd0,1,1,1,1,1,7'd3,6'b100000},
        '{1,0,0,4'd0,1,0,0,1,1,7'd3,6'b010110},
        '{1,0,0,4'd0,0,1,1,1,1,7'd3,6'b000010},
        '{1,0,0,4'd0,1,1,1,1,1,7'd3,6'b100010},
        '{0,0,0,4'd0,1,1,1,1,1,7'd3,6'b000010},
        '{1,1,1,4'd2,1,1,1,1,1,7'd3,6'b100010},
        '{1,1,1,4'd2,1,0,1,0,1,7'd3,6'b101010},
        '{1,1,1,4'd2,1,0,1,1,1,7'd3,6'b100010},
        '{1,1,1,4'd2,1,0,1,0,1,7'd3,6'b001010},
        '{1,1,1,4'd2,1,1,1,1,1,7'd3,6'b100010},
        '{1,1,1,4'd2,1,0,1,0,0,7'd3,6'b001101},
        '{1,1,1,4'd2,1,1,1,1,1,7'd3,6'b000000},
        '{0,1,1,4'd2,1,1,1,1,1,7'd3,6'b000000},
        '{1,1,1,4'd2,1,1,1,1,1,7'd3,6'b100000}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic release_bus();
        dma_ack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; eot_n = 1'b1;
        tick();
    endtask

    task automatic take_byte(input logic wr, input logic eot);
        dma_ack_n = 1'b0;
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        eot_n = ~eot;
        tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    initial begin
        // R1 reset state
        repeat (3) tick();
        chk("R1 outputs in reset", {3'b0, dreq, fifo_rd_stb, fifo_wr_stb, buf_done, dma_irq}, 8'h00);
        rst_n = 1'b1;
        tick();
        chk("R1 outputs after reset", {2'b0, dreq, fifo_rd_stb, fifo_wr_stb, buf_done, buf_sel, dma_irq}, 8'h00);

        // table walk
        for (int i = 0; i < 18; i++) begin
            dma_en = VEC[i].en; dir_wr = VEC[i].dir; burst_mode = VEC[i].bm;
            burst_len = VEC[i].blen; buf_ready = VEC[i].rdy; dma_ack_n = VEC[i].ackn;
            rd_n = VEC[i].rdn; wr_n = VEC[i].wrn; eot_n = VEC[i].eotn; pkt_len = VEC[i].plen;
            tick();
            chk($sformatf("table vector %0d (R2 R3 R4 R5 R6 R8 R9 R11)", i),
                {2'b0, dreq, fifo_rd_stb, fifo_wr_stb, buf_done, buf_sel, dma_irq},
                {2'b0, VEC[i].exp});
        end

        // R10 bytes while disabled are ignored
        dma_en = 1'b0; dir_wr = 1'b0; burst_mode = 1'b0;
        tick();
        take_byte(1'b0, 1'b0);
        chk("R10 no strobe while disabled", {6'b0, fifo_rd_stb, dreq}, 8'h00);
        release_bus();

        // R8 R9 read termination: interrupt, no handover
        dma_en = 1'b1; buf_ready = 1'b1; pkt_len = 7'd10;
        tick();
        chk("R2 request for ready read buffer", {7'b0, dreq}, 8'h01);
        take_byte(1'b0, 1'b1);
        chk("R8 R9 read termination", {3'b0, dreq, fifo_rd_stb, buf_done, buf_sel, dma_irq}, 8'h09);
        release_bus();
        chk("R8 stop held and single irq", {6'b0, dreq, dma_irq}, 8'h00);
        dma_en = 1'b0;
        tick();

        // R6 short packet in burst mode
        dma_en = 1'b1; burst_mode = 1'b1; burst_len = 4'd8; pkt_len = 7'd2;
        tick();
        chk("R2 request again after re-enable", {7'b0, dreq}, 8'h01);
        take_byte(1'b0, 1'b0);
        chk("R6 short packet handover", {4'b0, dreq, buf_done, buf_sel, fifo_rd_stb}, 8'h07);
        release_bus();
        chk("R6 request for next packet", {7'b0, dreq}, 8'h01);
        dma_en = 1'b0;
        tick();

        // R5 burst length 0 behaves as 1
        dma_en = 1'b1; burst_len = 4'd0; pkt_len = 7'd64;
        tick();
        take_byte(1'b0, 1'b0);
        chk("R5 burst_len 0 drops after one byte", {6'b0, dreq, buf_done}, 8'h00);
        release_bus();
        chk("R5 request after release", {7'b0, dreq}, 8'h01);
        pkt_len = 7'd2;
        take_byte(1'b0, 1'b0);
        chk("R6 R11 second byte ends buffer", {5'b0, buf_done, buf_sel, dreq}, 8'h04);
        release_bus();
        dma_en = 1'b0;
        tick();

        // R7 R11 full write buffer
        dma_en = 1'b1; dir_wr = 1'b1; burst_mode = 1'b0;
        tick();
        chk("R2 write request", {7'b0, dreq}, 8'h01);
        for (int b = 1; b <= 64; b++) begin
            take_byte(1'b1, 1'b0);
            if (b == 63 || b == 64)
                chk($sformatf("R7 R11 commit at byte %0d", b), {6'b0, buf_done, fifo_wr_stb},
                    {6'b0, (b == 64), 1'b1});
            if (b == 64) buf_ready = 1'b0;
            release_bus();
        end
        chk("R7 buffer toggled, no request when busy", {6'b0, buf_sel, dreq}, 8'h02);
        buf_ready = 1'b1;
        tick();
        chk("R7 request resumes when buffer free", {7'b0, dreq}, 8'h01);

        summary();
    end
endmodule